// File: doc/BRIEF.md
# Spectral Conversion Sequencer

This block paces the conversion cycles of a six-channel sensor front end and publishes each completed set of readings through a small byte-wide register port. One integration period lasts a programmable number of prescaled ticks. A two-bit bank field in the control register picks the sequence. Three settings run continuously. The fourth runs a one-shot burst of two periods and then halts until software writes that setting again.

When a set of results is complete, all six 16-bit channel words are captured from the stimulus input at once and a data-ready flag is raised. If interrupts are enabled, an active-low interrupt line is also pulled low. The line and the flag are cleared by different reads. A control-register read releases the line. A read of any result byte clears the flag. Results are read one byte at a time, high byte first. Reading a high byte freezes a copy of the matching low byte, so a capture that lands between the two reads cannot tear the word.

Every control-register write restarts the integration timer and the sequence from the beginning of a period.

Top module: `spec_conv_seq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00: data-ready in bit 1, bank in bits 3:2 and interrupt enable in bit 6 all clear. The interrupt output is high and every result byte reads 0x00.
- R2: In bank 0 or 1, a ready event occurs L = PRESCALE*(itime+1) clocks after the clock edge of the control write, and every L clocks after that. itime is the 8-bit register at address 1.
- R3: In bank 2 or 3, the first ready event occurs 2L clocks after the control write.
- R4: A ready event sets control bit 1. It drives int_no low only when control bit 6 is 1. With bit 6 at 0, int_no stays high.
- R5: Once low, int_no stays low until the control register is read. Reads of result bytes do not release it.
- R6: A read of any result byte (addresses 2 to 13) clears control bit 1. A control read returns the value before any clear and does not clear it.
- R7: Reading the high byte of a result freezes that result's low byte at its current value. The freeze holds until that low byte is read or another result's high byte is read.
- R8: Banks 0 to 2 keep converting. Each ready event overwrites the results with the input sampled at that event, and int_no stays low if it is not released.
- R9: Bank 3 runs exactly two periods, produces one ready event and stops. The results then stay unchanged, and no further events occur until bank 3 is written again. Each such write starts a fresh two-period run.
- R10: A write to the itime register takes effect at the next period boundary, not during the current period.
- R11: If a ready event coincides with a result read, data-ready ends set. If it coincides with a control read, int_no ends low.
- R12: Channel k (0 to 5) is taken from chan_data_i[16k+15:16k]. Its high byte is at address 2+2k and its low byte at 3+2k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_rd_i | input | 1 | Read strobe, one cycle; applies read side effects |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| chan_data_i | input | 96 | Six 16-bit channel samples from the front end |
| int_no | output | 1 | Active-low data-ready interrupt |

## Verification
The timing of ready events is measured in clocks from the control write for each bank and several itime values. This separates the single-period banks from the double-period ones and exposes off-by-one errors in the prescaler or the period counter. Random bank, period and channel patterns are checked against a latency function and the captured words. Directed cases cover the rest. Reads landing exactly on the ready edge show whether set beats clear. A capture between the high and low byte reads shows whether the shadow holds or the lock is released correctly. A period change made mid-cycle shows whether it is deferred. Idle time after a one-shot burst shows whether the sequence really stops.

// File: rtl/spec_conv_pkg.sv
package spec_conv_pkg;
  localparam int unsigned NUM_CH   = 6;
  localparam int unsigned RES_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned CH_IDX_W = $clog2(NUM_CH);

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_ITIME    = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES_BASE = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_RES_END  = ADDR_W'(2 + 2 * NUM_CH);

  typedef enum logic [1:0] {
    BANK_CONT_A    = 2'd0,
    BANK_CONT_B    = 2'd1,
    BANK_CONT_PAIR = 2'd2,
    BANK_ONE_SHOT  = 2'd3
  } bank_e;
endpackage

// File: rtl/spec_int_timer.sv
module spec_int_timer #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned ITIME_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [ITIME_W-1:0] itime_i,
  output logic               cycle_end_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]   pre_q;
  logic [ITIME_W-1:0] unit_q, period_q;
  logic               tick;

  assign tick        = (pre_q == PRE_W'(PRESCALE - 1));
  assign cycle_end_o = run_i && !restart_i && tick && (unit_q == period_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      unit_q   <= '0;
      period_q <= '0;
    end else if (restart_i) begin
      pre_q    <= '0;
      unit_q   <= '0;
      period_q <= itime_i;
    end else if (run_i) begin
      if (tick) begin
        pre_q <= '0;
        if (unit_q == period_q) begin
          unit_q   <= '0;
          period_q <= itime_i;  // new period only at boundary
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R10
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_end_o && !restart_i) |=> $stable(period_q))
    else $error("period changed mid-cycle");
endmodule

// File: rtl/spec_seq_ctrl.sv
module spec_seq_ctrl
  import spec_conv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] bank_i,
  input  logic       start_i,
  input  logic       cycle_end_i,
  output logic       run_o,
  output logic       ready_o
);
  logic phase_q, shot_run_q, one_shot;

  assign one_shot = (bank_i == BANK_ONE_SHOT);
  assign run_o    = !one_shot || shot_run_q;
  // bank[1] set: result after second period
  assign ready_o  = cycle_end_i && (!bank_i[1] || phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= 1'b0;
      shot_run_q <= 1'b0;
    end else if (start_i) begin
      phase_q    <= 1'b0;
      shot_run_q <= 1'b1;
    end else begin
      if (cycle_end_i && bank_i[1]) phase_q <= ~phase_q;
      if (ready_o && one_shot) shot_run_q <= 1'b0;
    end
  end

  // R9
  shot_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && one_shot && !start_i) |=> !run_o)
    else $error("one-shot did not halt");

  // R3
  pair_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i) |=> !ready_o)
    else $error("ready right after start");
endmodule

// File: rtl/spec_result_bank.sv
module spec_result_bank
  import spec_conv_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [NUM_CH*RES_W-1:0] data_i,
  input  logic                    rd_i,
  input  logic [CH_IDX_W-1:0]     rd_idx_i,
  input  logic                    rd_hi_i,
  output logic [BYTE_W-1:0]       rdata_o
);
  logic [RES_W-1:0]    res_q [NUM_CH];
  logic [RES_W-1:0]    sel_word;
  logic [BYTE_W-1:0]   shadow_q;
  logic [CH_IDX_W-1:0] lock_idx_q;
  logic                lock_q, hi_rd, lo_rd, lock_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     res_q[g] <= '0;
      else if (load_i) res_q[g] <= data_i[g*RES_W +: RES_W];
    end
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_idx_i == CH_IDX_W'(i)) sel_word = res_q[i];
  end

  assign hi_rd    = rd_i && rd_hi_i;
  assign lo_rd    = rd_i && !rd_hi_i;
  assign lock_hit = lock_q && (lock_idx_q == rd_idx_i);
  assign rdata_o  = rd_hi_i ? sel_word[RES_W-1:BYTE_W]
                  : (lock_hit ? shadow_q : sel_word[BYTE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      shadow_q   <= '0;
    end else if (hi_rd) begin
      lock_q     <= 1'b1;
      lock_idx_q <= rd_idx_i;
      shadow_q   <= sel_word[BYTE_W-1:0];
    end else if (lo_rd && lock_hit) begin
      lock_q <= 1'b0;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !hi_rd) |=> $stable(shadow_q))
    else $error("shadow byte moved while locked");
endmodule

// File: rtl/spec_conv_seq.sv
module spec_conv_seq
  import spec_conv_pkg::*;
#(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned ITIME_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [BYTE_W-1:0]       reg_wdata_i,
  output logic [BYTE_W-1:0]       reg_rdata_o,
  input  logic [NUM_CH*RES_W-1:0] chan_data_i,
  output logic                    int_no
);
  logic [1:0]          bank_q;
  logic [ITIME_W-1:0]  itime_q;
  logic                ien_q, rdy_q, int_q;
  logic                ctrl_wr, itime_wr, ctrl_rd, is_res, res_rd;
  logic                run, ready, cycle_end;
  logic [CH_IDX_W-1:0] res_idx;
  logic [BYTE_W-1:0]   res_rdata;
  logic                unused_wbits;

  assign ctrl_wr  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign itime_wr = reg_wr_i && (reg_addr_i == ADDR_ITIME);
  assign ctrl_rd  = reg_rd_i && (reg_addr_i == ADDR_CTRL);
  assign is_res   = (reg_addr_i >= ADDR_RES_BASE) && (reg_addr_i < ADDR_RES_END);
  assign res_rd   = reg_rd_i && is_res;
  assign res_idx  = CH_IDX_W'(reg_addr_i[ADDR_W-1:1]) - CH_IDX_W'(1);
  assign unused_wbits = ^{reg_wdata_i[7], reg_wdata_i[5:4], reg_wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= BANK_CONT_A;
      ien_q   <= 1'b0;
      itime_q <= '0;
    end else begin
      if (ctrl_wr) begin
        bank_q <= reg_wdata_i[3:2];
        ien_q  <= reg_wdata_i[6];
      end
      if (itime_wr) itime_q <= reg_wdata_i[ITIME_W-1:0];
    end
  end

  // set has priority over clear for both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (ready)       rdy_q <= 1'b1;
      else if (res_rd) rdy_q <= 1'b0;
      if (ready && ien_q) int_q <= 1'b1;
      else if (ctrl_rd)   int_q <= 1'b0;
    end
  end

  spec_int_timer #(.PRESCALE(PRESCALE), .ITIME_W(ITIME_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .restart_i   (ctrl_wr),
    .itime_i     (itime_q),
    .cycle_end_o (cycle_end)
  );

  spec_seq_ctrl u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bank_i      (bank_q),
    .start_i     (ctrl_wr),
    .cycle_end_i (cycle_end),
    .run_o       (run),
    .ready_o     (ready)
  );

  spec_result_bank u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ready),
    .data_i   (chan_data_i),
    .rd_i     (res_rd),
    .rd_idx_i (res_idx),
    .rd_hi_i  (!reg_addr_i[0]),
    .rdata_o  (res_rdata)
  );

  always_comb begin
    if (reg_addr_i == ADDR_CTRL)       reg_rdata_o = {1'b0, ien_q, 2'b00, bank_q, rdy_q, 1'b0};
    else if (reg_addr_i == ADDR_ITIME) reg_rdata_o = BYTE_W'(itime_q);
    else if (is_res)                   reg_rdata_o = res_rdata;
    else                               reg_rdata_o = '0;
  end

  assign int_no = ~int_q;

  // R11
  rdy_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |=> rdy_q) else $error("ready event lost");
  // R6
  rdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_rd && !ready) |=> !rdy_q) else $error("data-ready not cleared");
  // R5
  int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_no && !ctrl_rd) |=> !int_no) else $error("interrupt released early");
  // R4
  int_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> $past(ien_q)) else $error("interrupt while disabled");
endmodule

// File: tb/sim_spec_conv_seq.sv
module sim_spec_conv_seq;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [95:0] chan = '0;
  logic        int_n;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  spec_conv_seq #(.PRESCALE(PRE), .ITIME_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr_en),
    .reg_rd_i(rd_en), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .chan_data_i(chan), .int_no(int_n));

  function automatic int lat(int mode, int it);
    return PRE * (it + 1) * ((mode >= 2) ? 2 : 1);
  endfunction

  function automatic logic [7:0] ctrl_val(logic ien, logic [1:0] mode, logic rdy);
    return {1'b0, ien, 2'b00, mode, rdy, 1'b0};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // control write at edge 0, release read at edge 1
  task automatic set_mode(logic [1:0] mode, logic ien);
    logic [7:0] d;
    wr(4'd0, ctrl_val(ien, mode, 1'b0));
    rd(4'd0, d);
  endtask

  task automatic wait_int(output int n);
    n = 0;
    while (int_n !== 1'b0 && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic set_chan(logic [15:0] v [6]);
    for (int k = 0; k < 6; k++) chan[k*16 +: 16] = v[k];
  endtask

  task automatic read_word(int k, output logic [15:0] w);
    logic [7:0] h, l;
    rd(4'(2 + 2*k), h);
    rd(4'(3 + 2*k), l);
    w = {h, l};
  endtask

  task automatic check_all(string tag, logic [15:0] v [6]);
    logic [15:0] w;
    for (int k = 0; k < 6; k++) begin
      read_word(k, w);
      check(tag, w, v[k]);
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] va [6], vb [6], vc [6];
    logic [15:0] w;
    logic [7:0]  d;
    int n;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, d);  check("R1 ctrl reset", d, 8'h00);
    rd(4'd4, d);  check("R1 result reset", d, 8'h00);
    check("R1 int reset", int_n, 1);

    // R2, R12 basic mode 0
    for (int k = 0; k < 6; k++) va[k] = 16'($urandom);
    set_chan(va);
    wr(4'd1, 8'd1);
    set_mode(2'd0, 1'b1);
    wait_int(n);  check("R2 mode0 latency", n, lat(0, 1) - 1);
    rd(4'd0, d);  check("R6 ctrl shows rdy before clear", d, ctrl_val(1, 0, 1));
    rd(4'd2, d);  check("R12 ch0 high byte", d, va[0][15:8]);
    rd(4'd0, d);  check("R6 rdy cleared by result read", d, ctrl_val(1, 0, 0));
    check("R5 int released by ctrl read", int_n, 1);
    check_all("R12 words", va);
    wait_int(n);
    rd(4'd3, d);  check("R5 result read keeps int", int_n, 0);
    rd(4'd0, d);  check("R5 ctrl read releases int", int_n, 1);

    // R2 / R3 bank latencies
    wr(4'd1, 8'd0); set_mode(2'd1, 1'b1);
    wait_int(n);  check("R2 mode1 latency", n, lat(1, 0) - 1);
    wr(4'd1, 8'd1); set_mode(2'd2, 1'b1);
    wait_int(n);  check("R3 mode2 latency", n, lat(2, 1) - 1);
    wr(4'd1, 8'd2); set_mode(2'd3, 1'b1);
    wait_int(n);  check("R3 mode3 latency", n, lat(3, 2) - 1);

    // R9 one-shot halts, results frozen, retrigger
    rd(4'd0, d);  rd(4'd2, d);
    for (int k = 0; k < 6; k++) vb[k] = 16'($urandom);
    set_chan(vb);
    repeat (60) @(negedge clk);
    check("R9 no event after one-shot", int_n, 1);
    rd(4'd0, d);  check("R9 rdy stays clear", d, ctrl_val(1, 3, 0));
    read_word(1, w); check("R9 results unchanged", w, va[1]);
    set_mode(2'd3, 1'b1);
    wait_int(n);  check("R9 retrigger latency", n, lat(3, 2) - 1);
    read_word(1, w); check("R9 new capture", w, vb[1]);

    // R8 continuous overwrite, int stays low
    wr(4'd1, 8'd0); set_mode(2'd0, 1'b1);
    wait_int(n);
    set_chan(va);
    repeat (10) @(negedge clk);
    check("R8 int stays low", int_n, 0);
    read_word(5, w); check("R8 overwritten", w, va[5]);

    // R7 shadow
    wr(4'd1, 8'd3); set_mode(2'd0, 1'b1);
    wait_int(n);
    rd(4'd6, d);  check("R7 hi byte A", d, va[2][15:8]);
    set_chan(vb);
    rd(4'd0, d);  wait_int(n);
    rd(4'd7, d);  check("R7 low byte frozen", d, va[2][7:0]);
    read_word(2, w); check("R7 after release", w, vb[2]);
    rd(4'd6, d);
    for (int k = 0; k < 6; k++) vc[k] = 16'($urandom);
    set_chan(vc);
    rd(4'd0, d);  wait_int(n);
    rd(4'd10, d); check("R7 other hi byte", d, vc[4][15:8]);
    rd(4'd7, d);  check("R7 lock moved away", d, vc[2][7:0]);

    // R10 period change at boundary
    wr(4'd1, 8'd1); set_mode(2'd0, 1'b1);
    wr(4'd1, 8'd3);
    wait_int(n);  check("R10 old period kept", n, 6);
    rd(4'd0, d);  wait_int(n);  check("R10 new period", n, lat(0, 3) - 1);
    rd(4'd0, d);  wait_int(n);  check("R10 new period again", n, lat(0, 3) - 1);

    // R11 coincident set and clear
    wr(4'd1, 8'd1); set_mode(2'd0, 1'b1);
    repeat (6) @(negedge clk);
    rd(4'd2, d);
    rd(4'd0, d);  check("R11 rdy set wins", d, ctrl_val(1, 0, 1));
    repeat (6) @(negedge clk);
    rd(4'd0, d);  check("R11 int set wins", int_n, 0);

    // R4 interrupt disabled
    wr(4'd1, 8'd0); set_mode(2'd0, 1'b0);
    repeat (20) @(negedge clk);
    check("R4 int masked", int_n, 1);
    rd(4'd0, d);  check("R4 rdy still set", d, ctrl_val(0, 0, 1));

    // random mix
    for (int it = 0; it < 10; it++) begin
      int m, t;
      m = int'($urandom % 4);
      t = int'($urandom % 4);
      for (int k = 0; k < 6; k++) va[k] = 16'($urandom);
      set_chan(va);
      wr(4'd1, 8'(t));
      set_mode(2'(m), 1'b1);
      wait_int(n);  check(m >= 2 ? "R3 random latency" : "R2 random latency", n, lat(m, t) - 1);
      rd(4'd0, d);  check("R4 random ctrl", d, ctrl_val(1, 2'(m), 1));
      check_all("R12 random words", va);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule